// File: doc/BRIEF.md
# Four-Function Shared-Adder ALU

This block is a purely combinational arithmetic logic unit of parameterised width. It has two operands, a carry input and a 2-bit operation code. It produces a result word and one carry bit. A single ripple adder serves both addition and subtraction. For subtraction, an operand steering stage feeds the adder the bitwise complement of the second operand and ties the adder's carry input high. The adder then computes A plus the two's complement of B.

A bitwise AND unit and a bitwise OR unit work alongside the adder on the same operands, all at once. A final 4-to-1 selector, driven only by the operation code, chooses which unit's output leaves the block. The block has no clock, no reset and no stored state. The surrounding datapath places it wherever an n-bit add, subtract or logic operation with a carry is needed.

Top module: `alu4_shared`

## Requirements
- R1: With op = 2'b00 (add), {cout, result} equals the (WIDTH+1)-bit sum A + B + cin.
- R2: With op = 2'b01 (subtract), result equals (A - B) modulo 2^WIDTH.
- R3: With op = 2'b01, cout is the raw adder carry of A + ~B + 1. It is 1 when A >= B as unsigned numbers (no borrow) and 0 when a borrow occurs.
- R4: With op = 2'b10, result is the bitwise AND of A and B, and cout is 0.
- R5: With op = 2'b11, result is the bitwise OR of A and B, and cout is 0.
- R6: For op values 2'b01, 2'b10 and 2'b11, cin has no effect on result or cout.
- R7: Subtracting equal operands gives result 0 with cout 1, including the all-zero and all-ones operands.
- R8: For every op value, the outputs depend only on the current inputs. No clock or reset is involved, and WIDTH (default 8) sets every operand and result width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand (subtrahend on subtract) |
| cin | input | 1 | Carry input, used only by add |
| op | input | 2 | Operation: 00 add, 01 subtract, 10 AND, 11 OR |
| result | output | WIDTH | Selected unit output |
| cout | output | 1 | Adder carry on add/subtract (no-borrow flag on subtract), 0 otherwise |

## Verification
The checker assumes the operands, cin and op carry known 0/1 values whenever they are evaluated, and that its combinational checks see the outputs after the block has settled. The stimulus therefore changes inputs only on one clock edge of the bench and compares outputs on the opposite edge, and it never drives X or Z. A 4-bit instance is swept over every combination of operands, carry and op. A default-width instance covers the zero, all-ones and equal-operand corners.

// File: rtl/alu4_pkg.sv
package alu4_pkg;

    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_SUB = 2'b01,
        OP_AND = 2'b10,
        OP_OR  = 2'b11
    } alu_op_e;

endpackage

// File: rtl/alu4_operand_steer.sv
module alu4_operand_steer
    import alu4_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] b_in,
    input  logic             cin,
    input  alu_op_e          op,
    output logic [WIDTH-1:0] b_to_adder,
    output logic             cin_to_adder
);

    logic is_sub;

    // opcode comparator: subtract selects complement and forced carry
    assign is_sub = (op == OP_SUB);

    always_comb begin
        b_to_adder   = is_sub ? ~b_in : b_in;
        cin_to_adder = is_sub ? 1'b1 : cin;
    end

endmodule

// File: rtl/alu4_ripple_adder.sv
module alu4_ripple_adder #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    input  logic             ci,
    output logic [WIDTH-1:0] s,
    output logic             co
);

    logic [WIDTH:0] carry;

    assign carry[0] = ci;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign s[i]       = x[i] ^ y[i] ^ carry[i];
        assign carry[i+1] = (x[i] & y[i]) | (carry[i] & (x[i] ^ y[i]));
    end

    assign co = carry[WIDTH];

endmodule

// File: rtl/alu4_logic_unit.sv
module alu4_logic_unit #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    output logic [WIDTH-1:0] and_out,
    output logic [WIDTH-1:0] or_out
);

    assign and_out = x & y;
    assign or_out  = x | y;

endmodule

// File: rtl/alu4_shared.sv
module alu4_shared
    import alu4_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    input  logic [1:0]       op,
    output logic [WIDTH-1:0] result,
    output logic             cout
);

    alu_op_e           op_e;
    logic [WIDTH-1:0]  add_b;
    logic              add_cin;
    logic [WIDTH-1:0]  add_sum;
    logic              add_co;
    logic [WIDTH-1:0]  and_val;
    logic [WIDTH-1:0]  or_val;

    assign op_e = alu_op_e'(op);

    alu4_operand_steer #(.WIDTH(WIDTH)) u_steer (
        .b_in         (b),
        .cin          (cin),
        .op           (op_e),
        .b_to_adder   (add_b),
        .cin_to_adder (add_cin)
    );

    alu4_ripple_adder #(.WIDTH(WIDTH)) u_adder (
        .x  (a),
        .y  (add_b),
        .ci (add_cin),
        .s  (add_sum),
        .co (add_co)
    );

    alu4_logic_unit #(.WIDTH(WIDTH)) u_logic (
        .x       (a),
        .y       (b),
        .and_out (and_val),
        .or_out  (or_val)
    );

    // output selector: the only place the opcode picks a unit
    always_comb begin
        unique case (op_e)
            OP_ADD, OP_SUB: begin
                result = add_sum;
                cout   = add_co;
            end
            OP_AND: begin
                result = and_val;
                cout   = 1'b0;
            end
            OP_OR: begin
                result = or_val;
                cout   = 1'b0;
            end
            default: begin
                result = '0;
                cout   = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/alu4_shared_chk.sv
module alu4_shared_chk #(
    parameter int WIDTH = 8
) (
    input logic [WIDTH-1:0] a,
    input logic [WIDTH-1:0] b,
    input logic             cin,
    input logic [1:0]       op,
    input logic [WIDTH-1:0] result,
    input logic             cout,
    input logic             add_cin,
    input logic [WIDTH-1:0] add_b
);

    logic [WIDTH:0] sum_ref;
    logic [WIDTH:0] dif_ref;

    always_comb begin
        sum_ref = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};
        dif_ref = {1'b0, a} - {1'b0, b};
        if (op == 2'b00) begin
            a_r1_add_sum : assert ({cout, result} == sum_ref)
                else $error("R1 add mismatch");
        end
        if (op == 2'b01) begin
            a_r2_sub_diff : assert (result == dif_ref[WIDTH-1:0])
                else $error("R2 sub mismatch");
            a_r3_sub_noborrow : assert (cout == (a >= b))
                else $error("R3 borrow mismatch");
            a_r6_sub_forced_cin : assert (add_cin == 1'b1 && add_b == ~b)
                else $error("R6 steering mismatch");
        end
        if (op == 2'b10) begin
            a_r4_and : assert (result == (a & b) && !cout)
                else $error("R4 and mismatch");
        end
        if (op == 2'b11) begin
            a_r5_or : assert (result == (a | b) && !cout)
                else $error("R5 or mismatch");
        end
    end

endmodule

bind alu4_shared alu4_shared_chk #(.WIDTH(WIDTH)) u_chk (
    .a       (a),
    .b       (b),
    .cin     (cin),
    .op      (op),
    .result  (result),
    .cout    (cout),
    .add_cin (add_cin),
    .add_b   (add_b)
);

// File: tb/tb_alu4_shared.sv
module tb_alu4_shared;

    localparam int W  = 4;
    localparam int W8 = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic [W-1:0]  a, b, res;
    logic          cin, cout;
    logic [1:0]    op;

    logic [W8-1:0] a8, b8, res8;
    logic          cin8, cout8;
    logic [1:0]    op8;

    int vecs = 0;
    int errs = 0;
    bit done = 1'b0;

    alu4_shared #(.WIDTH(W)) dut (
        .a(a), .b(b), .cin(cin), .op(op), .result(res), .cout(cout)
    );

    alu4_shared #(.WIDTH(W8)) dut8 (
        .a(a8), .b(b8), .cin(cin8), .op(op8), .result(res8), .cout(cout8)
    );

    task automatic apply4(input logic [1:0] o, input int x, input int y, input int c);
        @(posedge clk);
        op = o; a = W'(x); b = W'(y); cin = c[0];
        @(negedge clk);
    endtask

    task automatic apply8(input logic [1:0] o, input int x, input int y, input int c);
        @(posedge clk);
        op8 = o; a8 = W8'(x); b8 = W8'(y); cin8 = c[0];
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input int got_r, input int got_c,
                       input int exp_r, input int exp_c);
        vecs++;
        if (got_r != exp_r || got_c != exp_c) begin
            errs++;
            $display("FAIL %s: got result=%0h cout=%0d, expected result=%0h cout=%0d",
                     tag, got_r, got_c, exp_r, exp_c);
        end
    endtask

    initial begin
        op = 2'b00; a = '0; b = '0; cin = 1'b0;
        op8 = 2'b00; a8 = '0; b8 = '0; cin8 = 1'b0;
        @(negedge clk);
        // R8: zero inputs settle to zero with no clocking of the block
        chk("R8 idle 4-bit", int'(res), int'(cout), 0, 0);
        chk("R8 idle 8-bit", int'(res8), int'(cout8), 0, 0);

        // exhaustive 4-bit sweep
        for (int o = 0; o < 4; o++) begin
            for (int x = 0; x < 16; x++) begin
                for (int y = 0; y < 16; y++) begin
                    for (int c = 0; c < 2; c++) begin
                        int er, ec, s;
                        apply4(2'(o), x, y, c);
                        case (o)
                            0: begin s = x + y + c; er = s % 16; ec = (s >= 16) ? 1 : 0;
                                     chk("R1 add", int'(res), int'(cout), er, ec); end
                            1: begin er = (x - y + 16) % 16; ec = (x >= y) ? 1 : 0;
                                     chk("R2/R3 sub", int'(res), int'(cout), er, ec); end
                            2: begin er = x & y; ec = 0;
                                     chk("R4 and", int'(res), int'(cout), er, ec); end
                            default: begin er = x | y; ec = 0;
                                     chk("R5 or", int'(res), int'(cout), er, ec); end
                        endcase
                    end
                end
            end
        end

        // R6: cin toggled on non-add ops leaves outputs unchanged
        for (int o = 1; o < 4; o++) begin
            int r0, c0;
            apply8(2'(o), 8'h5A, 8'h3C, 0);
            r0 = int'(res8); c0 = int'(cout8);
            apply8(2'(o), 8'h5A, 8'h3C, 1);
            chk("R6 cin ignored", int'(res8), int'(cout8), r0, c0);
        end

        // R7: equal operands on subtract
        apply8(2'b01, 0, 0, 0);       chk("R7 sub 0-0", int'(res8), int'(cout8), 0, 1);
        apply8(2'b01, 255, 255, 0);   chk("R7 sub ff-ff", int'(res8), int'(cout8), 0, 1);
        apply8(2'b01, 8'h77, 8'h77, 1); chk("R7 sub equal", int'(res8), int'(cout8), 0, 1);

        // 8-bit corners
        apply8(2'b00, 255, 255, 1); chk("R1 add ff+ff+1", int'(res8), int'(cout8), 8'hFF, 1);
        apply8(2'b00, 255, 0, 1);   chk("R1 add wrap", int'(res8), int'(cout8), 0, 1);
        apply8(2'b01, 0, 1, 0);     chk("R3 borrow 0-1", int'(res8), int'(cout8), 8'hFF, 0);
        apply8(2'b01, 8'h80, 8'h01, 0); chk("R2 sub 80-01", int'(res8), int'(cout8), 8'h7F, 1);
        apply8(2'b10, 255, 8'hA5, 1); chk("R4 and ones", int'(res8), int'(cout8), 8'hA5, 0);
        apply8(2'b11, 0, 8'h5A, 1);   chk("R5 or zero", int'(res8), int'(cout8), 8'h5A, 0);
        apply8(2'b11, 255, 0, 0);     chk("R8 or 8-bit width", int'(res8), int'(cout8), 8'hFF, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errs++;
            $display("FAIL watchdog: got hang, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

endmodule